// File: doc/BRIEF.md
# Seven-Operand Carry-Save Column Reducer

This block adds seven unsigned N-bit operands in one pass. Every bit column holds a cell that reduces seven primary bits plus two incoming carries to two result bits and two outgoing carries. Inside each cell, a seven-input ones counter built from four full adders reports how many of the seven primary bits are set. One more full adder then merges the counter's lowest bit with the carries that arrive from the two columns below. The counter's upper bits leave the column toward the next column and the second-next column.

The outgoing carries depend only on the seven primary bits, so no carry ripples along the array. The two vectors that result, a sum vector and a carry vector, are each N+3 bits wide. A ripple carry-propagate adder merges them into an exact (N+3)-bit total.

Operands enter through a valid/ready port, and the three result vectors leave through a valid/ready port. A single output register sits between them. An operand set is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While the output is stalled, it holds its contents and accepts nothing. Within a transfer, `in_ops` must not change while `in_valid` is high and `in_ready` is low.

Top module: `col7_reducer`

## Requirements
- R1: While reset (`rst_n` low) is held and in the first cycle after it is released, `out_valid` is low.
- R2: An operand set accepted on a rising edge (`in_valid` and `in_ready` high) shows up with `out_valid` high after that same edge, a latency of one cycle. With `out_ready` held high, one set is accepted per cycle.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sum`, `out_carry` and `out_total` hold their values over the clock edge.
- R4: Operand k occupies `in_ops[k*N +: N]` for k = 0..6. (`out_sum` + `out_carry`) modulo 2^(N+3) equals the sum of the seven operands.
- R5: `out_total` equals the exact sum of the seven operands. It always fits in N+3 bits and never wraps.
- R6: When all seven operands are zero, `out_sum`, `out_carry` and `out_total` are all zero.
- R7: Bit 0 of `out_carry` is always 0, because no column feeds a carry into weight 2^0.
- R8: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R9: When all seven operands are 2^N-1, `out_total` is 7*(2^N-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Reducer can take an operand set |
| in_ops | input | 7*N | Seven packed operands, operand k at bits k*N +: N |
| out_valid | output | 1 | Result vectors present |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | N+3 | Sum vector of the reduction |
| out_carry | output | N+3 | Carry vector of the reduction |
| out_total | output | N+3 | Carry-propagated total |

## Verification
The bench builds the block with N = 8, which gives 11-bit results and eleven columns, three of them with no primary inputs. At that width, all-ones operands drive carries into the two widened top columns and make the top result bit matter, so the no-wrap claim is exercised. Alternating bit patterns load the two carry paths, into the next column and into the second-next column, in different mixes. A stalled output with a second operand set waiting checks back-pressure and the one-cycle latency.

// File: rtl/col7_pkg.sv
package col7_pkg;
  localparam int unsigned OPS     = 7;
  localparam int unsigned GROWTH  = 3;
  localparam int unsigned CNT_W   = 3;

  function automatic int unsigned res_width(input int unsigned n);
    return n + GROWTH;
  endfunction
endpackage

// File: rtl/col7_fa.sv
module col7_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/col7_count.sv
module col7_count
  import col7_pkg::*;
(
  input  logic [OPS-1:0]   bits_in,
  output logic [CNT_W-1:0] ones
);
  logic s_lo, c_lo, s_hi, c_hi, q0, c_mid, q1, q2;

  col7_fa u_fa_lo  (.x(bits_in[0]), .y(bits_in[1]), .z(bits_in[2]), .s(s_lo), .c(c_lo));
  col7_fa u_fa_hi  (.x(bits_in[3]), .y(bits_in[4]), .z(bits_in[5]), .s(s_hi), .c(c_hi));
  col7_fa u_fa_mid (.x(s_lo), .y(s_hi), .z(bits_in[6]), .s(q0), .c(c_mid));
  col7_fa u_fa_top (.x(c_lo), .y(c_hi), .z(c_mid), .s(q1), .c(q2));

  assign ones = {q2, q1, q0};

  always_comb begin
    p_count_ones_r4: assert (ones == CNT_W'($countones(bits_in)))
      else $error("ones counter disagrees with population count");
  end
endmodule

// File: rtl/col7_cell.sv
module col7_cell
  import col7_pkg::*;
(
  input  logic [OPS-1:0] prim,
  input  logic           cin_near,
  input  logic           cin_far,
  output logic           res_lo,
  output logic           res_hi,
  output logic           cout_near,
  output logic           cout_far
);
  logic [CNT_W-1:0] cnt;

  col7_count u_cnt (.bits_in(prim), .ones(cnt));

  col7_fa u_merge (.x(cnt[0]), .y(cin_near), .z(cin_far), .s(res_lo), .c(res_hi));

  assign cout_near = cnt[1];
  assign cout_far  = cnt[2];

  always_comb begin
    p_cell_balance_r4: assert (
      5'($countones(prim)) + 5'(cin_near) + 5'(cin_far) ==
      5'(res_lo) + 5'({res_hi, 1'b0}) + 5'({cout_near, 1'b0}) + 5'({cout_far, 2'b00}))
      else $error("column cell loses weight");
  end
endmodule

// File: rtl/col7_array.sv
module col7_array
  import col7_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned W = N + GROWTH
) (
  input  logic [OPS*N-1:0] ops,
  output logic [W-1:0]     sum_vec,
  output logic [W-1:0]     carry_vec
);
  logic [W-1:0] co_near, co_far, lo_bits, hi_bits;

  for (genvar i = 0; i < W; i++) begin : g_col
    logic [OPS-1:0] prim;
    logic           cin_n, cin_f;

    if (i < N) begin : g_live
      for (genvar k = 0; k < OPS; k++) begin : g_tap
        assign prim[k] = ops[k*N + i];
      end
    end else begin : g_pad
      assign prim = '0;
    end

    if (i >= 1) begin : g_cn
      assign cin_n = co_near[i-1];
    end else begin : g_cn0
      assign cin_n = 1'b0;
    end

    if (i >= 2) begin : g_cf
      assign cin_f = co_far[i-2];
    end else begin : g_cf0
      assign cin_f = 1'b0;
    end

    col7_cell u_cell (
      .prim(prim), .cin_near(cin_n), .cin_far(cin_f),
      .res_lo(lo_bits[i]), .res_hi(hi_bits[i]),
      .cout_near(co_near[i]), .cout_far(co_far[i])
    );
  end

  assign sum_vec   = lo_bits;
  assign carry_vec = {hi_bits[W-2:0], 1'b0};

  logic [W-1:0] op_total;
  always_comb begin
    op_total = '0;
    for (int k = 0; k < OPS; k++) op_total = op_total + W'(ops[k*N +: N]);
  end

  always_comb begin
    p_vec_sum_r4: assert (W'(sum_vec + carry_vec) == op_total)
      else $error("sum and carry vectors do not add to operand total");
    p_no_spill_r5: assert (!hi_bits[W-1] && !co_near[W-1] && !co_far[W-1] && !co_far[W-2])
      else $error("weight left the widened columns");
  end
endmodule

// File: rtl/col7_cpa.sv
module col7_cpa #(
  parameter int unsigned W = 11
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] total,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    col7_fa u_fa (.x(a[i]), .y(b[i]), .z(chain[i]), .s(total[i]), .c(chain[i+1]));
  end

  assign cout = chain[W];
endmodule

// File: rtl/col7_reducer.sv
module col7_reducer
  import col7_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned W = N + GROWTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPS*N-1:0] in_ops,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_sum,
  output logic [W-1:0]     out_carry,
  output logic [W-1:0]     out_total
);
  logic [W-1:0] sum_c, carry_c, total_c;
  logic         cpa_cout;

  col7_array #(.N(N)) u_array (.ops(in_ops), .sum_vec(sum_c), .carry_vec(carry_c));

  col7_cpa #(.W(W)) u_cpa (.a(sum_c), .b(carry_c), .total(total_c), .cout(cpa_cout));

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_carry <= '0;
      out_total <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sum   <= sum_c;
        out_carry <= carry_c;
        out_total <= total_c;
      end
    end
  end

  always_comb begin
    p_cpa_no_wrap_r5: assert (!cpa_cout)
      else $error("final adder overflowed the widened result");
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid)
    else $error("accepted set did not appear");

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_carry) && $stable(out_total))
    else $error("stalled result changed");

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready)
    else $error("input accepted during stall");

  p_total_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_total == W'(out_sum + out_carry))
    else $error("registered total disagrees with vectors");

  p_carry_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_carry[0])
    else $error("carry vector bit 0 set");
endmodule

// File: tb/sim_col7_reducer.sv
module sim_col7_reducer;
  localparam int unsigned N = 8;
  localparam int unsigned W = N + 3;
  localparam int unsigned NV = 8;

  localparam logic [7*N-1:0] VEC_OPS [NV] = '{
    56'h00_00_00_00_00_00_00,
    56'hFF_FF_FF_FF_FF_FF_FF,
    56'h07_06_05_04_03_02_01,
    56'h80_80_80_80_80_80_80,
    56'hAA_55_AA_55_AA_55_AA,
    56'h01_01_01_01_01_01_01,
    56'hFF_00_FF_00_FF_00_FF,
    56'h70_60_50_40_30_20_10
  };
  localparam logic [W-1:0] VEC_EXP [NV] = '{
    11'd0, 11'd1785, 11'd28, 11'd896, 11'd935, 11'd7, 11'd1020, 11'd448
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [7*N-1:0] in_ops = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_sum, out_carry, out_total;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  col7_reducer #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ops(in_ops), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_carry(out_carry), .out_total(out_total)
  );

  function automatic logic [W-1:0] ref_sum(input logic [7*N-1:0] v);
    logic [W-1:0] acc = '0;
    for (int k = 0; k < 7; k++) acc = acc + W'(v[k*N +: N]);
    return acc;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", W'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", W'(out_valid), 0);
    check("R8 ready when empty", W'(in_ready), 1);

    // table walk, back-to-back with out_ready high (R2, R4, R5, R7)
    out_ready = 1'b1;
    for (int v = 0; v < NV; v++) begin
      in_valid = 1'b1;
      in_ops = VEC_OPS[v];
      @(negedge clk);
      check("R2 valid one cycle later", W'(out_valid), 1);
      check("R5 total", out_total, VEC_EXP[v]);
      check("R5 bench sum", out_total, ref_sum(VEC_OPS[v]));
      check("R4 vector sum", W'(out_sum + out_carry), VEC_EXP[v]);
      check("R7 carry lsb", W'(out_carry[0]), 0);
      if (v == 0) begin
        check("R6 zero sum vec", out_sum, 0);
        check("R6 zero carry vec", out_carry, 0);
      end
      if (v == 1) check("R9 max operands", out_total, W'(7 * (2**N - 1)));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 drained", W'(out_valid), 0);

    // back-pressure (R3, R8)
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_ops = 56'h12_34_56_78_9A_BC_DE;
    @(negedge clk);
    held = ref_sum(56'h12_34_56_78_9A_BC_DE);
    check("R2 first set", out_total, held);
    in_ops = 56'hFF_FF_FF_FF_FF_FF_FF;
    check("R8 ready low in stall", W'(in_ready), 0);
    @(negedge clk);
    check("R3 valid held", W'(out_valid), 1);
    check("R3 total held", out_total, held);
    check("R3 vectors held", W'(out_sum + out_carry), held);
    out_ready = 1'b1;
    #0;
    check("R8 ready on drain", W'(in_ready), 1);
    @(negedge clk);
    check("R2 second set after drain", out_total, 11'd1785);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 empty", W'(out_valid), 0);

    // reset mid-stream (R1)
    in_valid = 1'b1;
    in_ops = 56'h01_01_01_01_01_01_01;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears valid", W'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule